// File: doc/BRIEF.md
# Lock-Protected Peripheral Clock Gate Controller

This block is a small register-controlled clock gating unit that sits on an APB slave port. It serves seven peripheral groups. Groups 0 to 3 are four serial links, group 4 is a pair of bus controllers that share one clock, group 5 is an Ethernet MAC and group 6 is a PCI bridge. For each group the block drives one clock-run qualifier and one core reset output. The qualifier is meant for a latch-based clock gating cell further down the clock tree. The core reset holds the peripheral in its default state.

Software controls the block through three registers. The first is a lock mask, which can always be written. The second is a run mask: a 1 lets that group's clock run and a 0 stops it. The third is a hold-in-reset mask. A bit of the run mask or the hold mask changes on a write only while the same bit of the lock mask is 1. The expected sequence for a peripheral is to open its lock bit, change its run or hold bit, then close the lock bit again. A stray write therefore cannot stop a clock or reset a core that software did not first unlock.

The run mask reaches its output through a register clocked on the falling edge of the bus clock. A downstream gating latch therefore only ever sees a change while the clock is low.

Top module: `periph_clkgate`

## Requirements
- R1: Reset state. After reset the lock mask reads 0x00, the run mask reads 0x7F and the hold mask reads 0x00. `gclk_en` is 0x7F and `core_rst` is 0x00. An asynchronous reset in mid-run restores all of these values.
- R2: The lock mask sits at byte offset 0x0. Any write to it takes effect in full on bits 6:0 and ignores bits 31:7.
- R3: The run mask sits at byte offset 0x4. On a write, bit i takes the written value only when lock bit i is 1. Otherwise bit i keeps its old value. Bits with different lock states may be mixed in one write.
- R4: The hold mask sits at byte offset 0x8 and follows the same per-bit lock rule as R3.
- R5: `core_rst[i]` is high exactly while hold bit i is 1. It changes right after the rising edge that accepts a write to offset 0x8, and at no other time.
- R6: After a rising edge that changes the run mask, `gclk_en` keeps its previous value until the next falling edge of `pclk`. From that falling edge on, it equals the run mask.
- R7: A write to any other offset, including an offset that is not word aligned such as 0x2, changes no register. A read of such an offset returns 0.
- R8: A read returns the current register value in bits 6:0 with bits 31:7 at zero. A read has no side effect.
- R9: Bit i of each mask controls only peripheral group i. The order is links 0 to 3 on bits 0 to 3, the bus controller pair on bit 4, Ethernet on bit 5 and PCI on bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address within the unit |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data; zero when no read is in progress |
| gclk_en | output | 7 | Per-group clock-run qualifier, updated on the falling edge |
| core_rst | output | 7 | Per-group core reset, active high |

## Verification
Two things can fall in the same cycle. The first is the masked update of the run mask on a rising edge. The second is the half-cycle handover of that mask to `gclk_en` on the following falling edge. The bench completes a write and samples `gclk_en` twice: once just after the rising edge, where it must still hold the old value, and once after the falling edge, where it must hold the new one. The bench also writes words whose bits lie partly under open lock bits and partly under closed ones, so that a write and the lock masking act on different bits in a single access. It judges the outcome both from read-back values and from the output pins.

// File: rtl/cg_pkg.sv
package cg_pkg;

  // Which of the three registers an access addresses.
  typedef enum logic [1:0] {
    CG_LOCK = 2'd0,
    CG_RUN  = 2'd1,
    CG_HOLD = 2'd2,
    CG_NONE = 2'd3
  } cg_sel_e;

  // Byte offsets inside the unit.
  localparam int unsigned CG_OFS_LOCK = 0;
  localparam int unsigned CG_OFS_RUN  = 4;
  localparam int unsigned CG_OFS_HOLD = 8;

endpackage

// File: rtl/cg_addr_dec.sv
module cg_addr_dec
  import cg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output cg_sel_e           sel,
  output logic              wr_stb,
  output logic              rd_act
);

  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(CG_OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(CG_OFS_RUN);
  localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(CG_OFS_HOLD);

  // The full address is compared, so aliases and unaligned offsets
  // fall through to CG_NONE.
  always_comb begin
    unique case (paddr)
      A_LOCK:  sel = CG_LOCK;
      A_RUN:   sel = CG_RUN;
      A_HOLD:  sel = CG_HOLD;
      default: sel = CG_NONE;
    endcase
  end

  assign wr_stb = psel & penable & pwrite;
  assign rd_act = psel & ~pwrite;

endmodule

// File: rtl/cg_lock_regs.sv
module cg_lock_regs
  import cg_pkg::*;
#(
  parameter int unsigned NUM_GRP = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  cg_sel_e            sel,
  input  logic [NUM_GRP-1:0] wdata,
  output logic [NUM_GRP-1:0] lock_q,
  output logic [NUM_GRP-1:0] run_q,
  output logic [NUM_GRP-1:0] hold_q
);

  logic lock_hit;
  logic run_hit;
  logic hold_hit;

  assign lock_hit = wr_stb && (sel == CG_LOCK);
  assign run_hit  = wr_stb && (sel == CG_RUN);
  assign hold_hit = wr_stb && (sel == CG_HOLD);

  // The lock mask itself is never protected.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (lock_hit) begin
      lock_q <= wdata;
    end
  end

  // One run flop and one hold flop per group, each with its own lock bit.
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bit
    logic run_b;
    logic hold_b;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_b <= 1'b1;
      end else if (run_hit && lock_q[g]) begin
        run_b <= wdata[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_b <= 1'b0;
      end else if (hold_hit && lock_q[g]) begin
        hold_b <= wdata[g];
      end
    end

    assign run_q[g]  = run_b;
    assign hold_q[g] = hold_b;
  end

endmodule

// File: rtl/cg_fall_stage.sv
module cg_fall_stage #(
  parameter int unsigned NUM_GRP = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] d,
  output logic [NUM_GRP-1:0] q
);

  // Captured while the clock is low, so a downstream gating latch
  // only ever sees a change in its closed phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '1;
    end else begin
      q <= d;
    end
  end

endmodule

// File: rtl/periph_clkgate.sv
module periph_clkgate
  import cg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_GRP = 7
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic [NUM_GRP-1:0] gclk_en,
  output logic [NUM_GRP-1:0] core_rst
);

  localparam int unsigned PAD_W = DATA_W - NUM_GRP;

  cg_sel_e            sel;
  logic               wr_stb;
  logic               rd_act;
  logic [NUM_GRP-1:0] lock_q;
  logic [NUM_GRP-1:0] run_q;
  logic [NUM_GRP-1:0] hold_q;

  cg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .sel     (sel),
    .wr_stb  (wr_stb),
    .rd_act  (rd_act)
  );

  cg_lock_regs #(.NUM_GRP(NUM_GRP)) u_regs (
    .clk    (pclk),
    .rst_n  (presetn),
    .wr_stb (wr_stb),
    .sel    (sel),
    .wdata  (pwdata[NUM_GRP-1:0]),
    .lock_q (lock_q),
    .run_q  (run_q),
    .hold_q (hold_q)
  );

  cg_fall_stage #(.NUM_GRP(NUM_GRP)) u_fall (
    .clk   (pclk),
    .rst_n (presetn),
    .d     (run_q),
    .q     (gclk_en)
  );

  assign core_rst = hold_q;

  // Read data is driven only during a read and is zero-extended.
  always_comb begin
    prdata = '0;
    if (rd_act) begin
      unique case (sel)
        CG_LOCK: prdata = {{PAD_W{1'b0}}, lock_q};
        CG_RUN:  prdata = {{PAD_W{1'b0}}, run_q};
        CG_HOLD: prdata = {{PAD_W{1'b0}}, hold_q};
        default: prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/periph_clkgate_chk.sv
module periph_clkgate_chk #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_GRP = 7
) (
  input logic               pclk,
  input logic               presetn,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [NUM_GRP-1:0] gclk_en,
  input logic [NUM_GRP-1:0] core_rst,
  input logic [NUM_GRP-1:0] lock_q,
  input logic [NUM_GRP-1:0] run_q,
  input logic [NUM_GRP-1:0] hold_q
);

  logic acc_wr;
  logic wr_hold;
  logic wr_unmapped;

  assign acc_wr      = psel && penable && pwrite;
  assign wr_hold     = acc_wr && (paddr == ADDR_W'(8));
  assign wr_unmapped = acc_wr && (paddr != ADDR_W'(0)) && (paddr != ADDR_W'(4))
                       && (paddr != ADDR_W'(8));

  AST_RUN_LOCKED: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> (((run_q ^ $past(run_q)) & ~$past(lock_q)) == '0)); // R3

  AST_HOLD_LOCKED: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> (((hold_q ^ $past(hold_q)) & ~$past(lock_q)) == '0)); // R4

  AST_RST_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_hold |=> $stable(core_rst)); // R5

  AST_GATE_FALL: assert property (@(negedge pclk) disable iff (!presetn)
    1'b1 |=> (gclk_en == $past(run_q))); // R6

  AST_UNMAPPED_NOP: assert property (@(posedge pclk) disable iff (!presetn)
    wr_unmapped |=> ($stable(lock_q) && $stable(run_q) && $stable(hold_q))); // R7

endmodule

bind periph_clkgate periph_clkgate_chk #(
  .ADDR_W  (ADDR_W),
  .NUM_GRP (NUM_GRP)
) u_chk (
  .pclk     (pclk),
  .presetn  (presetn),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .gclk_en  (gclk_en),
  .core_rst (core_rst),
  .lock_q   (lock_q),
  .run_q    (run_q),
  .hold_q   (hold_q)
);

// File: tb/periph_clkgate_bench.sv
module periph_clkgate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Read rows compare prdata with exp; write rows only drive the bus.
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 12'h004, 32'h0000_0000, 32'h00, 4'd3}, // R3 locked write
    '{1'b0, 12'h004, 32'h0,         32'h7F, 4'd3}, // R3 unchanged
    '{1'b1, 12'h000, 32'hFFFF_FF21, 32'h00, 4'd2}, // R2 open bits 0 and 5
    '{1'b0, 12'h000, 32'h0,         32'h21, 4'd2}, // R2 upper bits dropped
    '{1'b1, 12'h004, 32'h0000_0000, 32'h00, 4'd3}, // R3 mixed mask write
    '{1'b0, 12'h004, 32'h0,         32'h5E, 4'd3}, // R3 only open bits cleared
    '{1'b1, 12'h008, 32'h0000_007F, 32'h00, 4'd4}, // R4 mixed mask write
    '{1'b0, 12'h008, 32'h0,         32'h21, 4'd4}, // R4
    '{1'b1, 12'h00C, 32'h0000_007F, 32'h00, 4'd7}, // R7 unmapped write
    '{1'b0, 12'h00C, 32'h0,         32'h00, 4'd7}, // R7 unmapped read
    '{1'b0, 12'h008, 32'h0,         32'h21, 4'd8}, // R8 repeat read
    '{1'b1, 12'h000, 32'h0000_0000, 32'h00, 4'd2}, // R2 relock
    '{1'b1, 12'h004, 32'h0000_007F, 32'h00, 4'd3}, // R3 write while locked
    '{1'b0, 12'h004, 32'h0,         32'h5E, 4'd3}, // R3
    '{1'b1, 12'h002, 32'h0000_007F, 32'h00, 4'd7}, // R7 unaligned write
    '{1'b0, 12'h000, 32'h0,         32'h00, 4'd7}, // R7 lock untouched
    '{1'b1, 12'h000, 32'h0000_007F, 32'h00, 4'd2}, // R2 open all
    '{1'b1, 12'h008, 32'h0000_0000, 32'h00, 4'd4}, // R4
    '{1'b0, 12'h008, 32'h0,         32'h00, 4'd4}, // R4
    '{1'b1, 12'h004, 32'h0000_007F, 32'h00, 4'd3}, // R3
    '{1'b0, 12'h004, 32'h0,         32'h7F, 4'd3}  // R3
  };

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [6:0]  gclk_en;
  logic [6:0]  core_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  periph_clkgate u_periph_clkgate (
    .pclk     (pclk),
    .presetn  (presetn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .gclk_en  (gclk_en),
    .core_rst (core_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h, expected 0x%0h", req, act, exp);
    end
  endtask

  // Returns one time unit after the rising edge that commits the write.
  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge pclk); #1;
    penable = 1'b1;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge pclk); #1;
    penable = 1'b1;
    #1 d = prdata;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;

    // R1 reset state at the ports and through reads
    chk("R1 gclk_en after reset", 32'(gclk_en), 32'h7F);
    chk("R1 core_rst after reset", 32'(core_rst), 32'h00);
    apb_rd(12'h000, rd); chk("R1 lock mask", rd, 32'h00);
    apb_rd(12'h004, rd); chk("R1 run mask", rd, 32'h7F);
    apb_rd(12'h008, rd); chk("R1 hold mask", rd, 32'h00);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k].wr) begin
        apb_wr(VEC[k].addr, VEC[k].data);
      end else begin
        apb_rd(VEC[k].addr, rd);
        chk($sformatf("R%0d row %0d", VEC[k].req, k), rd, VEC[k].exp);
      end
    end
    chk("R5 core_rst after table", 32'(core_rst), 32'h00);

    // R6: change is held back until the falling edge
    apb_wr(12'h004, 32'h55);
    #1 chk("R6 before falling edge", 32'(gclk_en), 32'h7F);
    #5 chk("R6 after falling edge", 32'(gclk_en), 32'h55);

    // R5: core reset follows the hold mask right after the commit edge
    apb_wr(12'h008, 32'h12);
    #1 chk("R5 hold set", 32'(core_rst), 32'h12);
    apb_wr(12'h008, 32'h00);
    #1 chk("R5 hold cleared", 32'(core_rst), 32'h00);

    // R9: each group bit on its own
    for (int i = 0; i < 7; i++) begin
      apb_wr(12'h004, 32'(1) << i);
      #6 chk($sformatf("R9 group %0d alone", i), 32'(gclk_en), 32'(1) << i);
    end

    // R3 at the pins: only bit 0 open, so bit 6 stays on from the walk
    apb_wr(12'h000, 32'h01);
    apb_wr(12'h004, 32'h00);
    #6 chk("R3 partial lock at pins", 32'(gclk_en), 32'h40);
    apb_wr(12'h008, 32'h7F);
    #1 chk("R4 partial lock at pins", 32'(core_rst), 32'h01);

    // R1 reset in mid-run
    @(posedge pclk); #1 presetn = 1'b0;
    #2 chk("R1 async gclk_en", 32'(gclk_en), 32'h7F);
    chk("R1 async core_rst", 32'(core_rst), 32'h00);
    #20 presetn = 1'b1;
    apb_rd(12'h000, rd); chk("R1 lock after mid reset", rd, 32'h00);
    apb_rd(12'h008, rd); chk("R1 hold after mid reset", rd, 32'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule